// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational binary adder. It takes two unsigned operands and a carry-in and returns the sum, the carry-out, and a block-wide propagate and generate pair. It is meant as a building block for wider adders or arithmetic units that need a short carry path.

The operand width is divided into equal groups of bits. Each group forms its bit-level propagate (`a ^ b`) and generate (`a & b`) terms. It computes every internal carry as a flat sum-of-products of those terms and its own carry-in. It reports a group propagate (all bits propagate) and a group generate (the group produces a carry on its own).

A second lookahead level takes the group propagate and generate pairs together with the adder carry-in. From them it forms all group carry-ins and the final carry-out at the same time, so a carry never passes from one group to the next through a chain. The same second level also produces the block-wide propagate and generate outputs. With the defaults, the adder is 16 bits wide and has four groups of four bits. The width and the group size are parameters, and their legality is checked during elaboration.

Top module: `cla_adder2l`

## Requirements
- R1: For every a, b and cin, the 17-bit value {cout, sum} equals a + b + cin, with cin weighted 1.
- R2: When a & b is zero and cin is 0, sum equals a | b and cout is 0, because no position creates a carry.
- R3: When b is the bitwise inverse of a (a full propagate chain), the result depends on cin. With cin = 1, sum is all zeros and cout is 1. With cin = 0, sum is all ones and cout is 0.
- R4: grp_p is 1 exactly when a ^ b is all ones, and cin has no effect on it.
- R5: grp_g is 1 exactly when a + b, with cin excluded, is greater than 2^16 - 1. Changing cin does not change grp_g.
- R6: cout always equals grp_g | (grp_p & cin).
- R7: A carry created in bit 0 reaches bit 15. For example, a = 16'h0001, b = 16'h7FFF, cin = 0 gives sum 16'h8000 and cout 0. With cin = 1 the same operands give 16'h8001.
- R8: The carry out of group k (bits 4k+3..4k) equals the carry into group k+1. For example, a = 16'h000F, b = 16'h0001 gives 16'h0010, and a = 16'h0FFF, b = 16'h0001 gives 16'h1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of the top bit |
| grp_p | output | 1 | Block propagate: every bit position propagates |
| grp_g | output | 1 | Block generate: the operands alone produce a carry out |

## Verification
The block holds no state, so a wrong internal term shows at the ports in the same evaluation as the stimulus that exercises it. A wrong group propagate or generate corrupts the sum bits at the next group boundary. It can also break the relation between cout and the block-wide propagate and generate. Faults of this kind only appear when a carry has to cross a boundary. For that reason, the directed scenarios place generated carries just below bits 4, 8, 12 and 16 and run full propagate chains with both carry-in values. The checker compares every group carry-out with the second-level carry into the next group, and every group carry-in with the arithmetic carry into that bit.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // Default geometry of the adder.
   localparam int CLA_DEF_WIDTH = 16;
   localparam int CLA_DEF_GROUP = 4;

   // Largest group the flat carry network is allowed to build.
   localparam int CLA_MAX_FANIN = 8;

   // Number of groups for a given width and group size.
   function automatic int cla_num_groups(input int width, input int group);
      return width / group;
   endfunction

   // True when the width divides evenly into groups.
   function automatic bit cla_geometry_ok(input int width, input int group);
      return (group >= 2) && (width >= group) && ((width % group) == 0);
   endfunction

endpackage

// File: rtl/cla_carry_net.sv
// Flat lookahead carry network over N propagate/generate pairs.
// c[k] is the carry into position k; c[0] is cin and c[N] the carry out.
// Every carry is a two-level sum of products with no chaining.
module cla_carry_net #(
   parameter int N = 4
) (
   input  logic [N-1:0] p,
   input  logic [N-1:0] g,
   input  logic         cin,
   output logic [N:0]   c,
   output logic         pg,
   output logic         gg
);
   import cla_pkg::*;

   localparam int NC = N + 1;

   generate
      if (N < 1 || N > CLA_MAX_FANIN) begin : g_bad_n
         $error("cla_carry_net: N out of range");
      end
   endgenerate

   // gen_part[k]: carry into k produced by g terms alone.
   // prop_all[k]: every position below k propagates.
   logic [N:0] gen_part;
   logic [N:0] prop_all;

   always_comb begin
      logic run;
      logic term;
      gen_part    = '0;
      prop_all    = '0;
      prop_all[0] = 1'b1;
      for (int k = 1; k <= N; k++) begin
         run = 1'b1;
         for (int m = 0; m < k; m++) begin
            run = run & p[m];
         end
         prop_all[k] = run;
         for (int j = 0; j < k; j++) begin
            term = g[j];
            for (int m = j + 1; m < k; m++) begin
               term = term & p[m];
            end
            gen_part[k] = gen_part[k] | term;
         end
      end
   end

   assign c  = gen_part | (prop_all & {NC{cin}});
   assign pg = prop_all[N];
   assign gg = gen_part[N];

endmodule

// File: rtl/cla_group.sv
// One lookahead group: bit terms, flat internal carries, sum, group P/G.
module cla_group #(
   parameter int GW = 4
) (
   input  logic [GW-1:0] a,
   input  logic [GW-1:0] b,
   input  logic          cin,
   output logic [GW-1:0] sum,
   output logic          cout,
   output logic          grp_p,
   output logic          grp_g
);
   import cla_pkg::*;

   generate
      if (GW < 2 || GW > CLA_MAX_FANIN) begin : g_bad_gw
         $error("cla_group: GW out of range");
      end
   endgenerate

   logic [GW-1:0] bit_p;
   logic [GW-1:0] bit_g;
   logic [GW:0]   carry;

   assign bit_p = a ^ b;
   assign bit_g = a & b;

   cla_carry_net #(.N(GW)) u_net (
      .p   (bit_p),
      .g   (bit_g),
      .cin (cin),
      .c   (carry),
      .pg  (grp_p),
      .gg  (grp_g)
   );

   assign sum  = bit_p ^ carry[GW-1:0];
   assign cout = carry[GW];

endmodule

// File: rtl/cla_adder2l.sv
// Two-level carry-lookahead adder: groups plus a second lookahead level.
module cla_adder2l #(
   parameter int WIDTH = cla_pkg::CLA_DEF_WIDTH,
   parameter int GROUP = cla_pkg::CLA_DEF_GROUP
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             grp_p,
   output logic             grp_g
);
   import cla_pkg::*;

   localparam int NG = cla_num_groups(WIDTH, GROUP);

   generate
      if (!cla_geometry_ok(WIDTH, GROUP)) begin : g_bad_geom
         $error("cla_adder2l: WIDTH must be a multiple of GROUP");
      end
      if (NG > CLA_MAX_FANIN) begin : g_bad_ng
         $error("cla_adder2l: too many groups for one lookahead level");
      end
   endgenerate

   logic [NG-1:0] gp;
   logic [NG-1:0] gg;
   logic [NG-1:0] grp_cout;
   logic [NG:0]   l2_c;

   genvar gi;
   generate
      for (gi = 0; gi < NG; gi++) begin : g_grp
         cla_group #(.GW(GROUP)) u_grp (
            .a     (a[gi*GROUP +: GROUP]),
            .b     (b[gi*GROUP +: GROUP]),
            .cin   (l2_c[gi]),
            .sum   (sum[gi*GROUP +: GROUP]),
            .cout  (grp_cout[gi]),
            .grp_p (gp[gi]),
            .grp_g (gg[gi])
         );
      end
   endgenerate

   cla_carry_net #(.N(NG)) u_l2 (
      .p   (gp),
      .g   (gg),
      .cin (cin),
      .c   (l2_c),
      .pg  (grp_p),
      .gg  (grp_g)
   );

   assign cout = l2_c[NG];

endmodule

// File: rtl/cla_adder2l_chk.sv
// Checker bound to the adder top.
module cla_adder2l_chk #(
   parameter int WIDTH = 16,
   parameter int GROUP = 4
) (
   input logic [WIDTH-1:0]       a,
   input logic [WIDTH-1:0]       b,
   input logic                   cin,
   input logic [WIDTH-1:0]       sum,
   input logic                   cout,
   input logic                   grp_p,
   input logic                   grp_g,
   input logic [WIDTH/GROUP-1:0] grp_cout,
   input logic [WIDTH/GROUP:0]   l2_c
);
   localparam int NG = WIDTH / GROUP;

   always_comb begin
      logic [WIDTH:0] full;
      logic [WIDTH:0] nocin;
      full  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      nocin = {1'b0, a} + {1'b0, b};
      assert_sum_R1: assert ({cout, sum} == full)
         else $error("sum mismatch");
      assert_prop_R4: assert (grp_p == (&(a ^ b)))
         else $error("block propagate mismatch");
      assert_gen_R5: assert (grp_g == nocin[WIDTH])
         else $error("block generate mismatch");
      assert_cout_R6: assert (cout == (grp_g | (grp_p & cin)))
         else $error("carry out vs block P/G mismatch");
   end

   always_comb begin
      logic [WIDTH:0] part;
      logic [WIDTH:0] mask;
      for (int k = 1; k < NG; k++) begin
         mask = ({{WIDTH{1'b0}}, 1'b1} << (k * GROUP)) - 1'b1;
         part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{WIDTH{1'b0}}, cin};
         assert_grp_cin_R7: assert (l2_c[k] == part[k * GROUP])
            else $error("group carry-in mismatch");
      end
      for (int k = 0; k < NG; k++) begin
         assert_grp_link_R8: assert (grp_cout[k] == l2_c[k + 1])
            else $error("group carry-out vs next group carry-in mismatch");
      end
   end

endmodule

bind cla_adder2l cla_adder2l_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (
   .a        (a),
   .b        (b),
   .cin      (cin),
   .sum      (sum),
   .cout     (cout),
   .grp_p    (grp_p),
   .grp_g    (grp_g),
   .grp_cout (grp_cout),
   .l2_c     (l2_c)
);

// File: tb/cla_adder2l_bench.sv
module cla_adder2l_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         cin = 1'b0;
   logic [W-1:0] sum;
   logic         cout;
   logic         grp_p;
   logic         grp_g;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   cla_adder2l u_cla_adder2l (
      .a(a), .b(b), .cin(cin),
      .sum(sum), .cout(cout), .grp_p(grp_p), .grp_g(grp_g)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
      @(negedge clk);
      a = va; b = vb; cin = vc;
      @(posedge clk);
      #1;
   endtask

   // Full check of every output against values derived from R1, R4, R5, R6.
   task automatic apply_full(input string req, input logic [W-1:0] va,
                             input logic [W-1:0] vb, input logic vc);
      logic [W:0] e;
      logic [W:0] e0;
      apply(va, vb, vc);
      e  = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
      e0 = {1'b0, va} + {1'b0, vb};
      check(req, "sum",   {16'h0, sum},  {16'h0, e[W-1:0]});
      check(req, "cout",  {31'h0, cout}, {31'h0, e[W]});
      check(req, "grp_p", {31'h0, grp_p}, {31'h0, &(va ^ vb)});
      check(req, "grp_g", {31'h0, grp_g}, {31'h0, e0[W]});
   endtask

   task automatic t_zero_state;
      apply(16'h0000, 16'h0000, 1'b0);
      check("R1", "zero sum",  {16'h0, sum}, 32'h0);
      check("R1", "zero cout", {31'h0, cout}, 32'h0);
      check("R5", "zero grp_g", {31'h0, grp_g}, 32'h0);
      check("R4", "zero grp_p", {31'h0, grp_p}, 32'h0);
   endtask

   task automatic t_disjoint_R2;
      apply(16'hA5A5, 16'h5A5A, 1'b0);
      check("R2", "disjoint sum",  {16'h0, sum}, 32'h0000FFFF);
      check("R2", "disjoint cout", {31'h0, cout}, 32'h0);
      apply(16'h0F00, 16'h30F0, 1'b0);
      check("R2", "disjoint sum2", {16'h0, sum}, 32'h00003FF0);
      check("R2", "disjoint cout2", {31'h0, cout}, 32'h0);
   endtask

   task automatic t_chain_R3;
      apply(16'h1234, 16'hEDCB, 1'b1);
      check("R3", "chain cin1 sum",  {16'h0, sum}, 32'h0);
      check("R3", "chain cin1 cout", {31'h0, cout}, 32'h1);
      apply(16'h1234, 16'hEDCB, 1'b0);
      check("R3", "chain cin0 sum",  {16'h0, sum}, 32'h0000FFFF);
      check("R3", "chain cin0 cout", {31'h0, cout}, 32'h0);
      apply(16'hFFFF, 16'h0000, 1'b1);
      check("R3", "all ones + cin sum", {16'h0, sum}, 32'h0);
      check("R3", "all ones + cin cout", {31'h0, cout}, 32'h1);
   endtask

   task automatic t_prop_R4;
      apply(16'h00FF, 16'hFF00, 1'b0);
      check("R4", "grp_p set cin0", {31'h0, grp_p}, 32'h1);
      apply(16'h00FF, 16'hFF00, 1'b1);
      check("R4", "grp_p set cin1", {31'h0, grp_p}, 32'h1);
      apply(16'h00FF, 16'hFF01, 1'b1);
      check("R4", "grp_p clear one bit", {31'h0, grp_p}, 32'h0);
   endtask

   task automatic t_gen_R5;
      apply(16'hFFFF, 16'hFFFF, 1'b0);
      check("R5", "all ones grp_g", {31'h0, grp_g}, 32'h1);
      check("R1", "all ones sum", {16'h0, sum}, 32'h0000FFFE);
      apply(16'hFFFF, 16'h0001, 1'b1);
      check("R5", "grp_g exact overflow", {31'h0, grp_g}, 32'h1);
      apply(16'hFFFF, 16'h0000, 1'b1);
      check("R5", "grp_g ignores cin", {31'h0, grp_g}, 32'h0);
      apply(16'h8000, 16'h8000, 1'b0);
      check("R5", "grp_g top bits", {31'h0, grp_g}, 32'h1);
   endtask

   task automatic t_cout_rel_R6;
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] va;
         logic [W-1:0] vb;
         logic vc;
         va = W'($urandom);
         vb = (i % 4 == 0) ? ~va : W'($urandom);
         vc = 1'($urandom);
         apply(va, vb, vc);
         check("R6", "cout vs grp_g|grp_p&cin", {31'h0, cout},
               {31'h0, grp_g | (grp_p & vc)});
      end
   endtask

   task automatic t_ripple_R7;
      apply(16'h0001, 16'h7FFF, 1'b0);
      check("R7", "long carry sum", {16'h0, sum}, 32'h00008000);
      check("R7", "long carry cout", {31'h0, cout}, 32'h0);
      apply(16'h0001, 16'h7FFF, 1'b1);
      check("R7", "long carry cin sum", {16'h0, sum}, 32'h00008001);
   endtask

   task automatic t_boundary_R8;
      apply(16'h000F, 16'h0001, 1'b0);
      check("R8", "boundary 4", {16'h0, sum}, 32'h00000010);
      apply(16'h00FF, 16'h0001, 1'b0);
      check("R8", "boundary 8", {16'h0, sum}, 32'h00000100);
      apply(16'h0FFF, 16'h0001, 1'b0);
      check("R8", "boundary 12", {16'h0, sum}, 32'h00001000);
      apply(16'h0F0F, 16'h0F0F, 1'b1);
      check("R8", "two groups generate", {16'h0, sum}, 32'h00001E1F);
      apply(16'hF000, 16'h1000, 1'b0);
      check("R8", "boundary 16 cout", {31'h0, cout}, 32'h1);
   endtask

   task automatic t_random_R1;
      for (int i = 0; i < 200; i++) begin
         apply_full("R1", W'($urandom), W'($urandom), 1'($urandom));
      end
   endtask

   initial begin
      t_zero_state();
      t_disjoint_R2();
      t_chain_R3();
      t_prop_R4();
      t_gen_R5();
      t_cout_rel_R6();
      t_ripple_R7();
      t_boundary_R8();
      t_random_R1();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule